// File: doc/BRIEF.md
# Oversampled Converter Result Register Interface

This block sits between the decimation filter of one delta-sigma converter channel and a processor's register file. Each time the filter raises its new-sample strobe, the block stores the 24-bit filtered result in two read registers: a 16-bit main register and an 8-bit low-byte register. The main register always holds the sixteen most significant result bits. The low byte carries only as many extra bits as the selected oversampling ratio resolves. Those bits sit at the top of the byte and the rest of the byte is zero.

A buffer-full flag tells software that a fresh result is waiting. The flag is set on every captured sample. A read of the main register clears it, unless a write to that register happens in the same cycle. Because only the main register read clears the flag, software that reads the low byte first can treat a clear flag as proof that the whole result was taken. While the converter is switched off, reads return the last stored result if the flag is still set, and all ones if it is not.

Top module: `adc_result_regs`

## Requirements
- R1: After reset, main_o reads FFFFh, lsb_o reads FFh and full_o is 0.
- R2: A strobe on smp_valid_i while conv_en_i is 1 stores the result on that clock edge, so main_o shows the new value in the next cycle.
- R3: The low byte stored with a sample follows osr_i at the strobe. Code 0 (ratio 32) gives 00h. Code 1 (ratio 64) gives data[7:5] followed by five zeros. Code 2 (ratio 128) gives data[7:2] followed by two zeros. Code 3 (ratio 256) gives data[7:0].
- R4: main_o equals data[23:8] of the captured sample for every ratio code.
- R5: full_o becomes 1 on the same edge that stores a sample.
- R6: A pulse on rd_main_i with wr_main_i at 0 clears full_o on that edge. A pulse on rd_lsb_i leaves full_o unchanged.
- R7: When rd_main_i and wr_main_i are both 1, full_o stays set, and the stored data does not change.
- R8: When a sample strobe and a clearing read arrive in the same cycle, full_o stays 1 and the new sample is stored.
- R9: While conv_en_i is 0, the outputs show the last stored result if full_o is 1, and FFFFh / FFh if full_o is 0.
- R10: A strobe on smp_valid_i while conv_en_i is 0 is ignored: nothing is stored and full_o does not change.
- R11: While conv_en_i is 1, the outputs always show the stored result, even when full_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| conv_en_i | input | 1 | Converter enable |
| osr_i | input | 2 | Oversampling ratio code: 0=32, 1=64, 2=128, 3=256 |
| smp_valid_i | input | 1 | New-sample strobe from the filter |
| smp_data_i | input | 24 | Filter output, MSB aligned |
| rd_main_i | input | 1 | Read strobe for the main register |
| wr_main_i | input | 1 | Write strobe for the main register (data is not changed) |
| rd_lsb_i | input | 1 | Read strobe for the low-byte register |
| main_o | output | 16 | Main register read data |
| lsb_o | output | 8 | Low-byte register read data |
| full_o | output | 1 | Buffer-full flag |

## Verification
The bench builds the block with its default parameters: a 24-bit result and a 16-bit main register, which leaves an 8-bit low byte. With these values every ratio code can be checked against the exact low-byte masks of 0, 3, 6 and 8 kept bits. The same result word is applied under all four codes, so a wrong mask boundary shows up as a wrong bit. Directed sequences then cover the flag races, the read that is accompanied by a write, and both disabled read cases.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;

  typedef enum logic [1:0] {
    OSR_32  = 2'd0,
    OSR_64  = 2'd1,
    OSR_128 = 2'd2,
    OSR_256 = 2'd3
  } osr_e;

  // number of resolved bits kept at the top of the low byte
  function automatic int lsb_keep(osr_e osr, int lsb_w);
    case (osr)
      OSR_32:  return 0;
      OSR_64:  return lsb_w - 5;
      OSR_128: return lsb_w - 2;
      default: return lsb_w;
    endcase
  endfunction

endpackage

// File: rtl/adc_res_format.sv
module adc_res_format
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 24,
  parameter int MAIN_W = 16,
  localparam int LSB_W = RES_W - MAIN_W
) (
  input  osr_e              osr_i,
  input  logic [RES_W-1:0]  data_i,
  output logic [MAIN_W-1:0] main_o,
  output logic [LSB_W-1:0]  lsb_o
);

  int keep;
  logic [LSB_W-1:0] mask;

  always_comb keep = lsb_keep(osr_i, LSB_W);

  assign main_o = data_i[RES_W-1 -: MAIN_W];

  for (genvar b = 0; b < LSB_W; b++) begin : g_mask
    assign mask[b] = (b >= LSB_W - keep);
  end

  assign lsb_o = data_i[LSB_W-1:0] & mask;

endmodule

// File: rtl/adc_res_store.sv
module adc_res_store
  import adc_res_pkg::*;
#(
  parameter int MAIN_W = 16,
  parameter int LSB_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  osr_e              osr_i,
  input  logic [MAIN_W-1:0] main_d_i,
  input  logic [LSB_W-1:0]  lsb_d_i,
  output logic [MAIN_W-1:0] main_q_o,
  output logic [LSB_W-1:0]  lsb_q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q_o <= '1;
      lsb_q_o  <= '1;
    end else if (load_i) begin
      main_q_o <= main_d_i;
      lsb_q_o  <= lsb_d_i;
    end
  end

  AST_LSB_ZERO_AT_32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && osr_i == OSR_32 |=> lsb_q_o == '0); // R3

  AST_FULL_BYTE_AT_256: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && osr_i == OSR_256 |=> lsb_q_o == $past(lsb_d_i)); // R3

  AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(main_q_o) && $stable(lsb_q_o)); // R7

endmodule

// File: rtl/adc_res_flag.sv
module adc_res_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic full_o
);

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     full_o <= 1'b0;
    else if (set_i)  full_o <= 1'b1;
    else if (clr_i)  full_o <= 1'b0;
  end

  AST_SET_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> full_o); // R5

  AST_CLEAR_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !full_o); // R6

  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !full_o |=> !full_o); // R10

endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
  import adc_res_pkg::*;
#(
  parameter int RES_W  = 24,
  parameter int MAIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_en_i,
  input  logic [1:0]        osr_i,
  input  logic              smp_valid_i,
  input  logic [RES_W-1:0]  smp_data_i,
  input  logic              rd_main_i,
  input  logic              wr_main_i,
  input  logic              rd_lsb_i,
  output logic [MAIN_W-1:0] main_o,
  output logic [RES_W-MAIN_W-1:0] lsb_o,
  output logic              full_o
);

  localparam int LSB_W = RES_W - MAIN_W;

  osr_e              osr;
  logic              take;
  logic              rd_clr;
  logic              blank;
  logic [MAIN_W-1:0] main_d, main_q;
  logic [LSB_W-1:0]  lsb_d, lsb_q;

  assign osr    = osr_e'(osr_i);
  assign take   = smp_valid_i & conv_en_i;
  // a write in the same cycle cancels the read side effect
  assign rd_clr = rd_main_i & ~wr_main_i;

  adc_res_format #(.RES_W(RES_W), .MAIN_W(MAIN_W)) i_format (
    .osr_i  (osr),
    .data_i (smp_data_i),
    .main_o (main_d),
    .lsb_o  (lsb_d)
  );

  adc_res_store #(.MAIN_W(MAIN_W), .LSB_W(LSB_W)) i_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (take),
    .osr_i    (osr),
    .main_d_i (main_d),
    .lsb_d_i  (lsb_d),
    .main_q_o (main_q),
    .lsb_q_o  (lsb_q)
  );

  adc_res_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (take),
    .clr_i  (rd_clr),
    .full_o (full_o)
  );

  assign blank  = ~conv_en_i & ~full_o;
  assign main_o = blank ? '1 : main_q;
  assign lsb_o  = blank ? '1 : lsb_q;

  AST_DISABLED_STROBE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && !conv_en_i && !full_o |=> !full_o); // R10

  AST_WRITE_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_main_i && wr_main_i && full_o |=> full_o); // R7

  AST_LSB_READ_NO_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_lsb_i && !rd_main_i && full_o |=> full_o); // R6

  AST_RACE_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && rd_main_i |=> full_o); // R8

  AST_MAIN_IS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> main_q == $past(smp_data_i[RES_W-1 -: MAIN_W])); // R4

endmodule

// File: tb/test_adc_result_regs.sv
module test_adc_result_regs;

  localparam time CLK = 20ns;
  localparam int  NV  = 10;
  // {osr, data, exp_main, exp_lsb}
  localparam logic [49:0] VEC [NV] = '{
    {2'd0, 24'hA5C3F1, 16'hA5C3, 8'h00},
    {2'd1, 24'hA5C3F1, 16'hA5C3, 8'hE0},
    {2'd2, 24'hA5C3F1, 16'hA5C3, 8'hF0},
    {2'd3, 24'hA5C3F1, 16'hA5C3, 8'hF1},
    {2'd1, 24'h123456, 16'h1234, 8'h40},
    {2'd2, 24'h123456, 16'h1234, 8'h54},
    {2'd3, 24'h00FF7F, 16'h00FF, 8'h7F},
    {2'd0, 24'hFFFFFF, 16'hFFFF, 8'h00},
    {2'd1, 24'h80001F, 16'h8000, 8'h00},
    {2'd2, 24'h7FFFFF, 16'h7FFF, 8'hFC}
  };

  logic        clk = 0, rst_n = 0;
  logic        conv_en = 0, smp_valid = 0, rd_main = 0, wr_main = 0, rd_lsb = 0;
  logic [1:0]  osr = 0;
  logic [23:0] smp_data = 0;
  logic [15:0] main_r;
  logic [7:0]  lsb_r;
  logic        full_r;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK/2) clk = ~clk;

  adc_result_regs i_adc_result_regs (
    .clk_i(clk), .rst_ni(rst_n), .conv_en_i(conv_en), .osr_i(osr),
    .smp_valid_i(smp_valid), .smp_data_i(smp_data), .rd_main_i(rd_main),
    .wr_main_i(wr_main), .rd_lsb_i(rd_lsb), .main_o(main_r), .lsb_o(lsb_r),
    .full_o(full_r)
  );

  task automatic chk(string req, logic [15:0] m, logic [7:0] l, logic f);
    total++;
    if (main_r !== m || lsb_r !== l || full_r !== f) begin
      bad++;
      $display("FAIL %s: got main=%h lsb=%h full=%b exp main=%h lsb=%h full=%b",
               req, main_r, lsb_r, full_r, m, l, f);
    end
  endtask

  // drive for one edge, release, sample at the next falling edge
  task automatic pulse(logic sv, logic [1:0] o, logic [23:0] d, logic rm, logic wm, logic rl);
    smp_valid = sv; osr = o; smp_data = d; rd_main = rm; wr_main = wm; rd_lsb = rl;
    @(negedge clk);
    smp_valid = 0; rd_main = 0; wr_main = 0; rd_lsb = 0;
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset", 16'hFFFF, 8'hFF, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 16'hFFFF, 8'hFF, 1'b0);
    conv_en = 1;

    for (int i = 0; i < NV; i++) begin
      pulse(1, VEC[i][49:48], VEC[i][47:24], 0, 0, 0);
      chk("R2 R3 R4 R5 capture", VEC[i][23:8], VEC[i][7:0], 1'b1);
      pulse(0, 0, 0, 0, 0, 1);
      chk("R6 lsb read keeps flag", VEC[i][23:8], VEC[i][7:0], 1'b1);
      pulse(0, 0, 0, 1, 0, 0);
      chk("R6 R11 main read clears", VEC[i][23:8], VEC[i][7:0], 1'b0);
    end

    // R7: read with write keeps flag and data
    pulse(1, 2'd3, 24'h3C5A96, 0, 0, 0);
    pulse(0, 0, 0, 1, 1, 0);
    chk("R7 read+write", 16'h3C5A, 8'h96, 1'b1);

    // R8: sample races a clearing read
    pulse(1, 2'd1, 24'h0102FF, 1, 0, 0);
    chk("R8 race", 16'h0102, 8'hE0, 1'b1);

    // R9: disabled with flag set shows last data
    conv_en = 0;
    @(negedge clk);
    chk("R9 disabled full", 16'h0102, 8'hE0, 1'b1);
    pulse(0, 0, 0, 1, 0, 0);
    chk("R9 disabled empty", 16'hFFFF, 8'hFF, 1'b0);

    // R10: strobe while disabled is ignored
    pulse(1, 2'd3, 24'hDEADBE, 0, 0, 0);
    chk("R10 disabled strobe", 16'hFFFF, 8'hFF, 1'b0);

    // R11: re-enable shows previous stored result, not the ignored one
    conv_en = 1;
    @(negedge clk);
    chk("R10 R11 re-enable", 16'h0102, 8'hE0, 1'b0);

    // R1: reset mid-run
    pulse(1, 2'd3, 24'h445566, 0, 0, 0);
    rst_n = 0;
    @(negedge clk);
    conv_en = 0;
    @(negedge clk);
    chk("R1 mid-run reset", 16'hFFFF, 8'hFF, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule